// File: doc/BRIEF.md
# Shadow ROM Region Decoder

This block classifies every memory access that a processor places near the top of the first megabyte, and at the copy of that area just below 16 MB. Each access ends in one of four region types: a ROM chip select, the external bus, a shadow read of internal RAM with the write suppressed, or plain internal RAM. The block also gives the physical RAM address for the access. This address carries the relocation that lets the RAM hidden behind the 640 KB to 1 MB hole appear above 1 MB.

Three control registers inside the block set the decode. A base register holds the shadow enable and the shape field. A chip-select register holds the ROM/external choice, and its upper nibble shows the chip revision. A revision-dependent status register reports whether more than 8 MB is installed. Software writes and reads these registers through a small indexed configuration port. The access side takes an address and a direction under a valid strobe. One cycle later it returns the region type, a write-blocked flag and the physical address, all registered. Installed memory size and chip revision come in as static inputs.

Top module: `shadowRomDecoder`

## Requirements
- R1: In reset, respValid is 0, regionType is 0 and writeBlocked is 0. The base register (index 0) reads 0x04. The chip-select register (index 4) reads {revision, 4'h0}.
- R2: An access presented with accValid high is answered in the next cycle: respValid is high for one cycle per access, and back-to-back accesses are answered back to back. regionType encodings: 0 internal RAM, 1 ROM chip select, 2 external bus, 3 shadow.
- R3: The shadow shape field is base register bits 4:3. It is honoured only while base register bit 2 is 1; when bit 2 is 0, no access is decoded as shadow.
- R4: Shape 2'b01 covers 0x0E0000–0x0EFFFF, shape 2'b10 covers 0x0F0000–0x0FFFFF, shape 2'b11 covers 0x0E0000–0x0FFFFF, and shape 2'b00 covers nothing. Each window is also active at the same offset within 0xFE0000–0xFFFFFF.
- R5: A shadow access returns physAddr equal to the access address with bits 23:20 cleared. writeBlocked is 1 for a shadow write and 0 for every other access.
- R6: A window is active only when memSizeKb is greater than its base address in KB: 896 for a window starting at 0x0E0000, 960 for one starting at 0x0F0000. Otherwise the default decode applies.
- R7: Without shadow, 0xFE0000–0xFFFFFF decodes as ROM chip select. 0x0E0000–0x0FFFFF decodes as ROM chip select when chip-select register bit 0 is 0, and as external bus when it is 1.
- R8: With revision 0 or 1, 0x0E0000–0x0FFFFF without shadow always decodes as ROM chip select, whatever chip-select register bit 0 holds.
- R9: When base register bit 2 is 0 and memSizeKb exceeds 640, a RAM access at or above 0x100000 (outside the top alias) gets physAddr = address − 0x60000. In every other case, a RAM access gets physAddr = address.
- R10: A write to index 0 loads all 8 bits of the base register. A write to index 4 changes only bits 3:0 of the chip-select register, and bits 7:4 keep the revision.
- R11: Index 6 reads 0 unless revision is 8. On revision 8 it reads the written bits 7:1 with bit 0 = (memSizeKb > 8192). Writes to index 6 on other revisions have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| revision | input | 4 | Chip revision number |
| memSizeKb | input | 16 | Installed RAM in KB |
| cfgWrEn | input | 1 | Configuration register write strobe |
| cfgIdx | input | 3 | Configuration register index (0, 4, 6) |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Configuration read data for cfgIdx (combinational) |
| accValid | input | 1 | Access strobe |
| accAddr | input | 24 | Access address |
| accWrite | input | 1 | Access direction, 1 = write |
| respValid | output | 1 | Decode result valid |
| regionType | output | 2 | Region type of the access |
| writeBlocked | output | 1 | Access was a write into a shadow window |
| physAddr | output | 24 | Physical RAM address of the access |

## Verification
The bench probes addresses on each side of every window edge (0x0DFFFF, 0x0E0000, 0x0EFFFF, 0x0F0000, 0x0FFFFF) and the matching offsets in the top alias, under each shape value. This separates the three window shapes from each other and from the default decode. The same addresses are repeated with the enable bit cleared, with a memory size between the two window bases, and with revisions 1, 2 and 8. These runs separate the enable gate, the memory-size gate and the revision rule for the chip select. Relocation is tried at 640 KB, 1 MB and 9 MB with the enable bit both set and cleared, to show the relocation turns on only in the intended combination.

// File: rtl/shadowDecPkg.sv
package shadowDecPkg;

  typedef enum logic [1:0] {
    REG_RAM    = 2'd0,
    REG_ROMCS  = 2'd1,
    REG_EXT    = 2'd2,
    REG_SHADOW = 2'd3
  } regionE;

  // Strobes from the control side to the decode datapath
  typedef struct packed {
    logic       accStrobe;
    logic       accWrite;
    logic [1:0] shadowSel;
    logic       lowIsRomcs;
    logic       relocOn;
  } ctrlStrobeT;

  localparam int CR_W = 8;

endpackage

// File: rtl/shadowCtrl.sv
module shadowCtrl
  import shadowDecPkg::*;
#(
  parameter int REV_W    = 4,
  parameter int MEM_KB_W = 16,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REV_W-1:0]    revision,
  input  logic [MEM_KB_W-1:0] memSizeKb,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [CR_W-1:0]     cfgWrData,
  output logic [CR_W-1:0]     cfgRdData,
  input  logic                accValid,
  input  logic                accWrite,
  output ctrlStrobeT          strobes
);

  localparam logic [IDX_W-1:0]    IDX_BASE   = IDX_W'(0);
  localparam logic [IDX_W-1:0]    IDX_CS     = IDX_W'(4);
  localparam logic [IDX_W-1:0]    IDX_STAT   = IDX_W'(6);
  localparam logic [REV_W-1:0]    REV_STAT   = REV_W'(8);
  localparam logic [REV_W-1:0]    REV_OLDMAX = REV_W'(1);
  localparam logic [MEM_KB_W-1:0] HOLE_KB    = MEM_KB_W'(640);
  localparam logic [MEM_KB_W-1:0] BIG_KB     = MEM_KB_W'(8192);
  localparam int                  LO_W       = CR_W - REV_W;

  logic [CR_W-1:0] baseReg;
  logic [CR_W-1:0] csReg;
  logic [CR_W-1:0] statReg;
  logic            statAvail;

  assign statAvail = (revision == REV_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= CR_W'(8'h04);
      csReg   <= {revision, {LO_W{1'b0}}};
      statReg <= '0;
    end else if (cfgWrEn) begin
      case (cfgIdx)
        IDX_BASE: baseReg <= cfgWrData;
        IDX_CS:   csReg[LO_W-1:0] <= cfgWrData[LO_W-1:0];
        IDX_STAT: if (statAvail) statReg <= {cfgWrData[CR_W-1:1], 1'b0};
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (cfgIdx)
      IDX_BASE: cfgRdData = baseReg;
      IDX_CS:   cfgRdData = csReg;
      IDX_STAT: cfgRdData = statAvail ? {statReg[CR_W-1:1], memSizeKb > BIG_KB} : '0;
      default:  cfgRdData = '0;
    endcase
  end

  always_comb begin
    strobes.accStrobe  = accValid;
    strobes.accWrite   = accWrite;
    strobes.shadowSel  = baseReg[2] ? baseReg[4:3] : 2'b00;
    strobes.lowIsRomcs = (revision <= REV_OLDMAX) || !csReg[0];
    strobes.relocOn    = !baseReg[2] && (memSizeKb > HOLE_KB);
  end

  AST_CS_REV_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    $stable(csReg[CR_W-1:LO_W])) else $error("revision nibble changed"); // R10

  AST_STAT_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    !statAvail |=> statReg == '0) else $error("status reg written on wrong revision"); // R11

endmodule

// File: rtl/ramRelocator.sv
module ramRelocator #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              relocOn,
  input  logic              inAlias,
  output logic [ADDR_W-1:0] addrOut
);

  localparam logic [ADDR_W-1:0] ONE_MEG  = ADDR_W'(32'h0010_0000);
  localparam logic [ADDR_W-1:0] HOLE_LEN = ADDR_W'(32'h0006_0000);

  always_comb begin
    if (relocOn && !inAlias && (addrIn >= ONE_MEG))
      addrOut = addrIn - HOLE_LEN;
    else
      addrOut = addrIn;
  end

endmodule

// File: rtl/regionDecode.sv
module regionDecode
  import shadowDecPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int MEM_KB_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobes,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [MEM_KB_W-1:0] memSizeKb,
  output logic                respValid,
  output logic [1:0]          regionType,
  output logic                writeBlocked,
  output logic [ADDR_W-1:0]   physAddr
);

  localparam int OFF_W   = 20;
  localparam int TOP_W   = ADDR_W - OFF_W;
  localparam int ALIAS_W = ADDR_W - 17;

  logic [OFF_W-1:0]  offset;
  logic              inLow;
  logic              inAlias;
  logic [3:0]        winHit;
  logic              shadowHit;
  logic [ADDR_W-1:0] relocAddr;
  regionE            nextType;
  logic              nextBlk;
  logic [ADDR_W-1:0] nextPhys;
  regionE            typeQ;

  assign offset  = accAddr[OFF_W-1:0];
  assign inLow   = (accAddr[ADDR_W-1:OFF_W] == '0) && (accAddr[19:17] == 3'b111);
  assign inAlias = (accAddr[ADDR_W-1:17] == {ALIAS_W{1'b1}});

  assign winHit[0] = 1'b0;
  for (genvar s = 1; s < 4; s++) begin : gWin
    localparam logic [OFF_W:0] W_BASE = (s == 2) ? 21'h0F0000 : 21'h0E0000;
    localparam logic [OFF_W:0] W_END  = W_BASE + ((s == 3) ? 21'h020000 : 21'h010000);
    localparam logic [MEM_KB_W-1:0] W_KB = MEM_KB_W'(W_BASE >> 10);
    assign winHit[s] = (strobes.shadowSel == 2'(s))
                    && ({1'b0, offset} >= W_BASE)
                    && ({1'b0, offset} <  W_END)
                    && (memSizeKb > W_KB);
  end
  assign shadowHit = |winHit;

  ramRelocator #(.ADDR_W(ADDR_W)) reloc_i (
    .addrIn  (accAddr),
    .relocOn (strobes.relocOn),
    .inAlias (inAlias),
    .addrOut (relocAddr)
  );

  always_comb begin
    nextBlk  = 1'b0;
    nextPhys = accAddr;
    if (shadowHit && (inLow || inAlias)) begin
      nextType = REG_SHADOW;
      nextBlk  = strobes.accWrite;
      nextPhys = {{TOP_W{1'b0}}, offset};
    end else if (inAlias) begin
      nextType = REG_ROMCS;
    end else if (inLow) begin
      nextType = strobes.lowIsRomcs ? REG_ROMCS : REG_EXT;
    end else begin
      nextType = REG_RAM;
      nextPhys = relocAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid    <= 1'b0;
      typeQ        <= REG_RAM;
      writeBlocked <= 1'b0;
      physAddr     <= '0;
    end else begin
      respValid <= strobes.accStrobe;
      if (strobes.accStrobe) begin
        typeQ        <= nextType;
        writeBlocked <= nextBlk;
        physAddr     <= nextPhys;
      end
    end
  end

  assign regionType = typeQ;

  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accStrobe |=> respValid) else $error("no response"); // R2

  AST_BLOCK_ONLY_SHADOW: assert property (@(posedge clk) disable iff (!rstN)
    writeBlocked |-> (typeQ == REG_SHADOW)) else $error("block outside shadow"); // R5

  AST_SHADOW_LOW_PHYS: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && typeQ == REG_SHADOW) |-> (physAddr[ADDR_W-1:OFF_W] == '0)) else $error("shadow phys high"); // R5

  AST_EXT_NOT_ALIAS: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && typeQ == REG_EXT) |-> (physAddr[ADDR_W-1:OFF_W] == '0)) else $error("alias went external"); // R7

endmodule

// File: rtl/shadowRomDecoder.sv
module shadowRomDecoder
  import shadowDecPkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int MEM_KB_W = 16,
  parameter int REV_W    = 4,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [REV_W-1:0]    revision,
  input  logic [MEM_KB_W-1:0] memSizeKb,
  input  logic                cfgWrEn,
  input  logic [IDX_W-1:0]    cfgIdx,
  input  logic [7:0]          cfgWrData,
  output logic [7:0]          cfgRdData,
  input  logic                accValid,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic                accWrite,
  output logic                respValid,
  output logic [1:0]          regionType,
  output logic                writeBlocked,
  output logic [ADDR_W-1:0]   physAddr
);

  ctrlStrobeT strobes;

  shadowCtrl #(.REV_W(REV_W), .MEM_KB_W(MEM_KB_W), .IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .revision  (revision),
    .memSizeKb (memSizeKb),
    .cfgWrEn   (cfgWrEn),
    .cfgIdx    (cfgIdx),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .strobes   (strobes)
  );

  regionDecode #(.ADDR_W(ADDR_W), .MEM_KB_W(MEM_KB_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .accAddr      (accAddr),
    .memSizeKb    (memSizeKb),
    .respValid    (respValid),
    .regionType   (regionType),
    .writeBlocked (writeBlocked),
    .physAddr     (physAddr)
  );

endmodule

// File: tb/shadowRomDecoder_tb_top.sv
`timescale 1ns/1ps
module shadowRomDecoder_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  revision = 4'd2;
  logic [15:0] memSizeKb = 16'd1024;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgIdx = 3'd0;
  logic [7:0]  cfgWrData = 8'h00;
  logic [7:0]  cfgRdData;
  logic        accValid = 1'b0;
  logic [23:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        respValid;
  logic [1:0]  regionType;
  logic        writeBlocked;
  logic [23:0] physAddr;

  int checks = 0;
  int errors = 0;

  // bench model of configuration state
  logic [7:0] mBase;
  logic [3:0] mCsLo;

  logic [26:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  shadowRomDecoder dut_i (
    .clk(clk), .rstN(rstN), .revision(revision), .memSizeKb(memSizeKb),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .respValid(respValid), .regionType(regionType), .writeBlocked(writeBlocked),
    .physAddr(physAddr)
  );

  function automatic logic [26:0] model(input logic [23:0] a, input logic wr);
    logic [1:0]  sel;
    logic [31:0] off, wBase, wSize;
    logic        lowR, aliasR, hit;
    sel    = mBase[2] ? mBase[4:3] : 2'b00;
    lowR   = (a >= 24'h0E0000) && (a < 24'h100000);
    aliasR = (a >= 24'hFE0000);
    off    = {12'h0, a[19:0]};
    wBase  = (sel == 2'b10) ? 32'hF0000 : 32'hE0000;
    wSize  = (sel == 2'b11) ? 32'h20000 : 32'h10000;
    hit    = (sel != 2'b00) && (off >= wBase) && (off < wBase + wSize)
             && ({16'h0, memSizeKb} * 32'd1024 > wBase);
    if (hit && (lowR || aliasR)) return {2'd3, wr, 4'h0, a[19:0]};
    if (aliasR) return {2'd1, 1'b0, a};
    if (lowR) return {((revision <= 4'd1) || !mCsLo[0]) ? 2'd1 : 2'd2, 1'b0, a};
    if (!mBase[2] && memSizeKb > 16'd640 && a >= 24'h100000) return {2'd0, 1'b0, a - 24'h060000};
    return {2'd0, 1'b0, a};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: push expectation, drive access for one cycle
  task automatic access(input logic [23:0] a, input logic wr, input string tag);
    @(negedge clk);
    expQ.push_back(model(a, wr));
    tagQ.push_back(tag);
    accValid = 1'b1;
    accAddr  = a;
    accWrite = wr;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    accValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        check("R2 unexpected response", 32'd1, 32'd0);
      end else begin
        logic [26:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {5'h0, regionType, writeBlocked, physAddr}, {5'h0, e});
      end
    end
  end

  task automatic cfgWrite(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    accValid  = 1'b0;
    cfgWrEn   = 1'b1;
    cfgIdx    = idx;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (idx == 3'd0) mBase = d;
    if (idx == 3'd4) mCsLo = d[3:0];
  endtask

  task automatic cfgRead(input logic [2:0] idx, input logic [7:0] exp, input string req);
    @(negedge clk);
    accValid = 1'b0;
    cfgIdx = idx;
    #2;
    check(req, {24'h0, cfgRdData}, {24'h0, exp});
  endtask

  task automatic doReset(input logic [3:0] rev, input logic [15:0] mem);
    @(negedge clk);
    accValid  = 1'b0;
    rstN      = 1'b0;
    revision  = rev;
    memSizeKb = mem;
    mBase = 8'h04;
    mCsLo = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 respValid", {31'h0, respValid}, 32'd0);
    check("R1 regionType", {30'h0, regionType}, 32'd0);
    check("R1 writeBlocked", {31'h0, writeBlocked}, 32'd0);
    cfgIdx = 3'd0; #2;
    check("R1 base reg", {24'h0, cfgRdData}, 32'h04);
    cfgIdx = 3'd4; #2;
    check("R1 cs reg", {24'h0, cfgRdData}, {24'h0, rev, 4'h0});
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // revision 2, 1 MB
    doReset(4'd2, 16'd1024);
    access(24'h0E0000, 1'b0, "R7 low romcs default");
    access(24'h0FFFFF, 1'b1, "R7 low romcs write");
    access(24'hFE0000, 1'b0, "R7 alias romcs");
    access(24'h050000, 1'b0, "R2 plain ram");
    access(24'h100000, 1'b0, "R9 no reloc while enable set");
    idle(2);
    cfgWrite(3'd4, 8'hF1);
    cfgRead(3'd4, 8'h21, "R10 cs low nibble only");
    access(24'h0F0000, 1'b0, "R7 low external");
    access(24'hFF8000, 1'b0, "R7 alias stays romcs");
    idle(2);
    cfgWrite(3'd0, 8'h1C);
    cfgRead(3'd0, 8'h1C, "R10 base full write");
    access(24'h0E0000, 1'b1, "R4 R5 shape3 write blocked");
    access(24'h0FFFFF, 1'b0, "R4 shape3 top read");
    access(24'hFE1234, 1'b1, "R5 alias shadow write");
    access(24'h0DFFFF, 1'b0, "R4 below window");
    idle(2);
    cfgWrite(3'd0, 8'h14);
    access(24'h0EFFFF, 1'b0, "R4 shape2 below");
    access(24'h0F0000, 1'b1, "R4 shape2 start");
    access(24'hFF0010, 1'b0, "R4 shape2 alias");
    idle(2);
    cfgWrite(3'd0, 8'h0C);
    access(24'h0E8000, 1'b1, "R4 shape1 inside");
    access(24'h0F0000, 1'b0, "R4 shape1 above");
    access(24'hFF0000, 1'b0, "R4 shape1 alias above");
    access(24'hFEFFFF, 1'b1, "R4 shape1 alias inside");
    idle(2);
    cfgWrite(3'd0, 8'h18);
    access(24'h0E0000, 1'b1, "R3 field ignored enable clear");
    access(24'h100000, 1'b0, "R9 reloc start");
    access(24'h150000, 1'b0, "R9 reloc mid");
    access(24'hFE0000, 1'b0, "R9 alias not relocated");
    idle(2);
    cfgRead(3'd6, 8'h00, "R11 status zero on rev2");

    // revision 1, 928 KB
    doReset(4'd1, 16'd928);
    cfgWrite(3'd4, 8'h01);
    access(24'h0F0000, 1'b0, "R8 old rev forces romcs");
    idle(2);
    cfgWrite(3'd0, 8'h1C);
    access(24'h0E0000, 1'b1, "R6 128K window above 896");
    idle(2);
    cfgWrite(3'd0, 8'h14);
    access(24'h0F0000, 1'b1, "R6 64K top window gated");
    access(24'hFF0000, 1'b1, "R6 alias gated");
    idle(2);
    cfgWrite(3'd6, 8'hFF);
    cfgRead(3'd6, 8'h00, "R11 write ignored on rev1");

    // revision 8, 9 MB
    doReset(4'd8, 16'd9216);
    cfgRead(3'd6, 8'h01, "R11 big memory bit");
    cfgWrite(3'd6, 8'hA4);
    cfgRead(3'd6, 8'hA5, "R11 written bits");
    memSizeKb = 16'd4096;
    cfgRead(3'd6, 8'hA4, "R11 small memory bit");
    memSizeKb = 16'd9216;
    cfgWrite(3'd0, 8'h00);
    access(24'h200000, 1'b0, "R9 reloc high ram");
    access(24'h0F0000, 1'b0, "R7 rev8 romcs");
    idle(2);

    // revision 2, 640 KB
    doReset(4'd2, 16'd640);
    cfgWrite(3'd0, 8'h00);
    access(24'h100000, 1'b0, "R9 no reloc at 640K");
    idle(1);
    cfgWrite(3'd0, 8'h1C);
    access(24'h0E0000, 1'b0, "R6 no shadow at 640K");
    access(24'h0E0000, 1'b1, "R2 back to back");
    idle(3);

    check("R2 all responses seen", expQ.size(), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule